// File: doc/BRIEF.md
# Channel Output Character Unpacker

This block feeds an output peripheral on one I/O channel, handing it one character at a time cut from 24-bit words. A character is 6, 12 or 24 bits wide. In 6-bit mode a word yields one to four characters, in 12-bit mode one or two characters, and in 24-bit mode one character. Words reach the block in one of two ways. With interlace on, the block refills itself from memory using an address register that counts up and a 15-bit word counter that counts down. With interlace off, the program loads one word at a time.

The device asks for a character in one of two ways. A synchronous request is always honoured, and finding no data then counts as a rate error. An asynchronous ready is parked as a wake flag when nothing is buffered. When the buffer runs empty, the block looks at its function code, the interlace state, the word count and any deferred terminate-output command. From these it decides whether to ask the device for an end-of-record write, to disconnect, or to raise an interrupt request. An end-of-record report from the device either ends the connection or leaves the channel parked between records.

Top module: `chan_out_unpacker`

## Requirements
- R1: After reset and after a connect, `connected` reflects the link, and no character, interrupt, end-of-record write, disconnect or rate error is reported. A connect is accepted only while disconnected.
- R2: In 6-bit mode (`conn_width`=0), a word gives `conn_cpw`+1 characters. They go out most-significant first, each taken from bits 23:18 of the word as it is shifted left 6 after every character, and each is right-justified on `char_data`.
- R3: In 12-bit mode (`conn_width`=1), a word gives `conn_cpw[0]`+1 characters, taken from bits 23:12 with a left shift of 12. In 24-bit mode (`conn_width`=2), one character equal to the whole word is sent.
- R4: With interlace on and the buffer empty, a transfer request causes exactly one `mem_req` at the current address. The data returned one cycle later fills the buffer. The address then goes up by one and the word count down by one.
- R5: `char_data` stays stable while `char_valid` is high, until the cycle in which `char_ack` is high.
- R6: A synchronous request (`dev_xfr`) that finds the buffer empty, interlace off and no end of record pending sets `rate_err` and produces no character.
- R7: In compatible mode (`conn_func`=000), when the last character of the word that brings the count to zero is sent, `irq_zwc` pulses if `ion` is high. The channel then disconnects (`disc` pulses and `connected` falls).
- R8: Extended functions use `conn_func` bit 2 = 1, bit 1 = signal and bit 0 = proceed. When the count reaches zero in one of these modes, `irq_zwc` pulses if it is enabled. Signal-disconnect also pulses `irq_eor` if that is enabled, then disconnects. Record functions request `wreor`. Signal-proceed requests `wreor` only when a terminate-output is pending.
- R9: When the buffer empties with interlace off, a pending terminate-output is consumed and `wreor` pulses. Without one, `irq_eow` pulses if `ion` is high.
- R10: A terminate-output (`top_cmd`) arriving while the buffer holds data or interlace is on is deferred. When the buffer is idle, it pulses `wreor` at once. A command that arrives in the very cycle the buffer empties is treated as pending for that emptying.
- R11: A program word load (`pword_valid`) is refused with a `pword_refused` pulse while the buffer holds data, and the buffer is left unchanged. An accepted load fills the buffer. If the wake flag is set, an accepted load re-raises the transfer request.
- R12: An asynchronous ready (`dev_ordy`) that finds no data and no interlace sets the wake flag. It produces no character and no rate error. A ready that arrives together with an accepted load starts a transfer.
- R13: An end-of-record report (`dev_eor`) pulses `irq_eor` when the mode is compatible with `ion` high, or when the end-of-record interrupt is enabled. Proceed functions then stay connected with `rec_gap` set. All other functions disconnect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conn_valid | input | 1 | Connect strobe |
| conn_width | input | 2 | Character width: 0 = 6-bit, 1 = 12-bit, 2 = 24-bit |
| conn_cpw | input | 2 | Characters per word minus one |
| conn_func | input | 3 | Function code: {extended, signal, proceed} |
| conn_zwc_en | input | 1 | Zero-word-count interrupt enable |
| conn_eor_en | input | 1 | End-of-record interrupt enable |
| ion | input | 1 | Interrupts on |
| ilc_valid | input | 1 | Interlace load strobe |
| ilc_addr | input | ADDR_W | Interlace start address |
| ilc_count | input | WC_W | Interlace word count |
| pword_valid | input | 1 | Program word load strobe |
| pword_data | input | WORD_W | Program word |
| pword_refused | output | 1 | Load refused pulse |
| top_cmd | input | 1 | Terminate-output command |
| dev_xfr | input | 1 | Synchronous device transfer request |
| dev_ordy | input | 1 | Asynchronous device ready |
| dev_eor | input | 1 | Device end-of-record report |
| char_valid | output | 1 | Character valid |
| char_data | output | WORD_W | Character, right-justified |
| char_ack | input | 1 | Device accepts character |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | WORD_W | Memory read data, one cycle after request |
| wreor | output | 1 | Write-end-of-record request pulse |
| disc | output | 1 | Disconnect pulse |
| irq_zwc | output | 1 | Zero-word-count interrupt pulse |
| irq_eor | output | 1 | End-of-record interrupt pulse |
| irq_eow | output | 1 | End-of-word interrupt pulse |
| rate_err | output | 1 | Rate error flag |
| connected | output | 1 | Channel connected |
| rec_gap | output | 1 | Parked between records |

## Verification
The delicate overlap is a terminate-output command landing in the same cycle as the emission that empties the buffer. The bench loads a single 24-bit word, raises the transfer request one cycle, and drives `top_cmd` on exactly the next cycle, which is when the character leaves. It then expects one `wreor` and no `irq_eow`. A later word with no command must give `irq_eow`, proving the pending flag was consumed rather than left standing. A second overlap is an asynchronous ready arriving in the cycle of an accepted program load, which must yield a character without any further request.

// File: rtl/chdis_pkg.sv
package chdis_pkg;

  typedef enum logic [1:0] {
    CW_6  = 2'd0,
    CW_12 = 2'd1,
    CW_24 = 2'd2
  } cwidth_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DATA = 2'd2
  } eng_st_t;

  // function code bit positions
  localparam int FN_EXT  = 2;
  localparam int FN_SIG  = 1;
  localparam int FN_PROC = 0;

  typedef struct packed {
    logic zwc;
    logic eor;
    logic eow;
    logic wreor;
    logic disc;
    logic clr_ilce;
    logic clr_top;
  } term_act_t;

  function automatic logic [1:0] eff_cpw(input logic [1:0] w, input logic [1:0] c);
    case (cwidth_t'(w))
      CW_6:    eff_cpw = c;
      CW_12:   eff_cpw = {1'b0, c[0]};
      default: eff_cpw = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/chdis_unpack.sv
module chdis_unpack
  import chdis_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        width,
  output logic [WORD_W-1:0] chr,
  output logic [WORD_W-1:0] rest
);
  localparam int QW = WORD_W / 4;
  localparam int HW = WORD_W / 2;

  always_comb begin
    case (cwidth_t'(width))
      CW_6: begin
        chr  = {{(WORD_W-QW){1'b0}}, word[WORD_W-1 -: QW]};
        rest = word << QW;
      end
      CW_12: begin
        chr  = {{(WORD_W-HW){1'b0}}, word[WORD_W-1 -: HW]};
        rest = word << HW;
      end
      default: begin
        chr  = word;
        rest = '0;
      end
    endcase
  end
endmodule

// File: rtl/chdis_ptr.sv
module chdis_ptr #(
  parameter int ADDR_W = 14,
  parameter int WC_W   = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [WC_W-1:0]   load_cnt,
  input  logic              step,
  output logic [ADDR_W-1:0] mar,
  output logic [WC_W-1:0]   wcr,
  output logic              wcr_zero
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mar <= '0;
      wcr <= '0;
    end else if (load) begin
      mar <= load_addr;
      wcr <= load_cnt;
    end else if (step) begin
      mar <= mar + 1'b1;
      wcr <= wcr - 1'b1;
    end
  end

  assign wcr_zero = (wcr == '0);

  // R4
  wcr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (wcr == $past(wcr) - 1'b1));

  // R4
  mar_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (mar == $past(mar) + 1'b1));
endmodule

// File: rtl/chdis_term.sv
module chdis_term
  import chdis_pkg::*;
(
  input  logic [2:0] func,
  input  logic       ilce,
  input  logic       wcr_zero,
  input  logic       top_eff,
  input  logic       ion,
  input  logic       zwc_en,
  input  logic       eor_en,
  output term_act_t  act
);
  always_comb begin
    act = '0;
    if (ilce) begin
      if (wcr_zero) begin
        act.clr_ilce = 1'b1;
        if (!func[FN_EXT]) begin
          act.zwc  = ion;
          act.disc = 1'b1;
        end else begin
          act.zwc     = zwc_en;
          act.clr_top = 1'b1;
          if (func[FN_SIG] && !func[FN_PROC]) begin
            act.eor  = eor_en;
            act.disc = 1'b1;
          end else if (!func[FN_SIG] || top_eff) begin
            act.wreor = 1'b1;
          end
        end
      end
    end else if (top_eff) begin
      act.clr_top = 1'b1;
      act.wreor   = 1'b1;
    end else begin
      act.eow = ion;
    end
  end
endmodule

// File: rtl/chan_out_unpacker.sv
module chan_out_unpacker
  import chdis_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 14,
  parameter int WC_W   = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conn_valid,
  input  logic [1:0]        conn_width,
  input  logic [1:0]        conn_cpw,
  input  logic [2:0]        conn_func,
  input  logic              conn_zwc_en,
  input  logic              conn_eor_en,
  input  logic              ion,
  input  logic              ilc_valid,
  input  logic [ADDR_W-1:0] ilc_addr,
  input  logic [WC_W-1:0]   ilc_count,
  input  logic              pword_valid,
  input  logic [WORD_W-1:0] pword_data,
  output logic              pword_refused,
  input  logic              top_cmd,
  input  logic              dev_xfr,
  input  logic              dev_ordy,
  input  logic              dev_eor,
  output logic              char_valid,
  output logic [WORD_W-1:0] char_data,
  input  logic              char_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              wreor,
  output logic              disc,
  output logic              irq_zwc,
  output logic              irq_eor,
  output logic              irq_eow,
  output logic              rate_err,
  output logic              connected,
  output logic              rec_gap
);
  localparam int CC_W = 3;

  eng_st_t           st;
  logic [WORD_W-1:0] war;
  logic [CC_W-1:0]   cc;
  logic [1:0]        width_r;
  logic [1:0]        cpw_r;
  logic [2:0]        func_r;
  logic              zwc_en_r, eor_en_r;
  logic              ilce, topp, owak, xfr, eorp;

  logic [ADDR_W-1:0] mar;
  logic [WC_W-1:0]   wcr;
  logic              wcr_zero;
  logic [WORD_W-1:0] chr, rest;
  term_act_t         act;

  logic              busy_data, idle_buf, load_ok, top_eff, eng_go;
  logic              do_eor, do_emit, do_fetch, do_rate, last_char;
  logic              disc_now, wreor_now;
  logic [CC_W-1:0]   full_cnt;

  assign busy_data = (cc != '0);
  assign idle_buf  = !busy_data && !ilce;
  assign load_ok   = pword_valid && connected && !busy_data && (st == ST_IDLE);
  assign top_eff   = topp || (top_cmd && connected);
  assign full_cnt  = CC_W'(eff_cpw(width_r, cpw_r)) + 1'b1;

  assign eng_go    = connected && (st == ST_IDLE);
  assign do_eor    = eng_go && eorp;
  assign do_emit   = eng_go && !eorp && xfr && !char_valid && busy_data;
  assign do_fetch  = eng_go && !eorp && xfr && !char_valid && !busy_data && ilce;
  assign do_rate   = eng_go && !eorp && xfr && !char_valid && !busy_data && !ilce;
  assign last_char = do_emit && (cc == CC_W'(1));

  assign disc_now  = (last_char && act.disc) || (do_eor && !func_r[FN_PROC]);
  assign wreor_now = ((last_char && act.wreor) ||
                      (top_cmd && connected && idle_buf)) && !disc_now;

  assign mem_req  = (st == ST_REQ);
  assign mem_addr = mar;

  chdis_ptr #(.ADDR_W(ADDR_W), .WC_W(WC_W)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .load      (ilc_valid && connected),
    .load_addr (ilc_addr),
    .load_cnt  (ilc_count),
    .step      (st == ST_DATA),
    .mar       (mar),
    .wcr       (wcr),
    .wcr_zero  (wcr_zero)
  );

  chdis_unpack #(.WORD_W(WORD_W)) u_unpack (
    .word  (war),
    .width (width_r),
    .chr   (chr),
    .rest  (rest)
  );

  chdis_term u_term (
    .func     (func_r),
    .ilce     (ilce),
    .wcr_zero (wcr_zero),
    .top_eff  (top_eff),
    .ion      (ion),
    .zwc_en   (zwc_en_r),
    .eor_en   (eor_en_r),
    .act      (act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      war           <= '0;
      cc            <= '0;
      width_r       <= '0;
      cpw_r         <= '0;
      func_r        <= '0;
      zwc_en_r      <= 1'b0;
      eor_en_r      <= 1'b0;
      ilce          <= 1'b0;
      topp          <= 1'b0;
      owak          <= 1'b0;
      xfr           <= 1'b0;
      eorp          <= 1'b0;
      char_valid    <= 1'b0;
      char_data     <= '0;
      pword_refused <= 1'b0;
      wreor         <= 1'b0;
      disc          <= 1'b0;
      irq_zwc       <= 1'b0;
      irq_eor       <= 1'b0;
      irq_eow       <= 1'b0;
      rate_err      <= 1'b0;
      connected     <= 1'b0;
      rec_gap       <= 1'b0;
    end else begin
      pword_refused <= pword_valid && !load_ok;
      irq_zwc       <= 1'b0;
      irq_eor       <= 1'b0;
      irq_eow       <= 1'b0;
      wreor         <= wreor_now;
      disc          <= 1'b0;

      if (char_valid && char_ack) char_valid <= 1'b0;

      if (conn_valid && !connected) begin
        width_r   <= conn_width;
        cpw_r     <= conn_cpw;
        func_r    <= conn_func;
        zwc_en_r  <= conn_zwc_en;
        eor_en_r  <= conn_eor_en;
        war       <= '0;
        cc        <= '0;
        ilce      <= 1'b0;
        topp      <= 1'b0;
        owak      <= 1'b0;
        xfr       <= 1'b0;
        eorp      <= 1'b0;
        rate_err  <= 1'b0;
        rec_gap   <= 1'b0;
        st        <= ST_IDLE;
        connected <= 1'b1;
      end else if (connected) begin
        if (ilc_valid) ilce <= 1'b1;
        if (dev_eor)   eorp <= 1'b1;
        if (dev_xfr)   xfr  <= 1'b1;
        if (dev_ordy) begin
          if (busy_data || ilce || load_ok) xfr <= 1'b1;
          else                              owak <= 1'b1;
        end
        if (load_ok) begin
          war <= pword_data;
          cc  <= full_cnt;
          if (owak) begin
            xfr  <= 1'b1;
            owak <= 1'b0;
          end
        end
        if (top_cmd && !idle_buf) topp <= 1'b1;

        // refill sequencer
        case (st)
          ST_REQ:  st <= ST_DATA;
          ST_DATA: begin
            war <= mem_rdata;
            cc  <= full_cnt;
            st  <= ST_IDLE;
          end
          default: if (do_fetch) st <= ST_REQ;
        endcase

        if (do_eor) begin
          eorp    <= 1'b0;
          ilce    <= 1'b0;
          irq_eor <= (!func_r[FN_EXT] && ion) || eor_en_r;
          if (func_r[FN_PROC]) rec_gap <= 1'b1;
        end

        if (do_rate) begin
          xfr      <= 1'b0;
          rate_err <= 1'b1;
        end

        if (do_emit) begin
          char_valid <= 1'b1;
          char_data  <= chr;
          war        <= rest;
          cc         <= cc - 1'b1;
          xfr        <= 1'b0;
          rec_gap    <= 1'b0;
        end

        if (last_char) begin
          irq_zwc <= act.zwc;
          irq_eor <= act.eor;
          irq_eow <= act.eow;
          if (act.clr_ilce) ilce <= 1'b0;
          if (act.clr_top)  topp <= 1'b0;
        end

        if (disc_now) begin
          disc      <= 1'b1;
          connected <= 1'b0;
          ilce      <= 1'b0;
          xfr       <= 1'b0;
          owak      <= 1'b0;
          topp      <= 1'b0;
          eorp      <= 1'b0;
        end
      end
    end
  end

  // R5
  char_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (char_valid && !char_ack) |=> (char_valid && $stable(char_data)));

  // R4
  mem_single_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R7
  disc_drop_chk: assert property (@(posedge clk) disable iff (rst)
    disc |-> !connected);

  // R11
  refuse_cause_chk: assert property (@(posedge clk) disable iff (rst)
    pword_refused |-> $past(pword_valid));

  // R6
  rate_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(rate_err) && !$past(rst)) |-> ($past(cc) == '0 && !$past(ilce)));

  // R9
  eow_excl_chk: assert property (@(posedge clk) disable iff (rst)
    irq_eow |-> (!wreor && !disc));
endmodule

// File: tb/test_chan_out_unpacker.sv
`timescale 1ns/1ps
module test_chan_out_unpacker;
  localparam int WW = 24, AW = 14, CW = 15;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic conn_valid; logic [1:0] conn_width, conn_cpw; logic [2:0] conn_func;
  logic conn_zwc_en, conn_eor_en, ion;
  logic ilc_valid; logic [AW-1:0] ilc_addr; logic [CW-1:0] ilc_count;
  logic pword_valid; logic [WW-1:0] pword_data; logic pword_refused;
  logic top_cmd, dev_xfr, dev_xfr_t, dev_xfr_m, dev_ordy, dev_eor;
  logic char_valid; logic [WW-1:0] char_data; logic char_ack;
  logic mem_req; logic [AW-1:0] mem_addr; logic [WW-1:0] mem_rdata;
  logic wreor, disc, irq_zwc, irq_eor, irq_eow, rate_err, connected, rec_gap;

  assign dev_xfr = dev_xfr_t | dev_xfr_m;

  chan_out_unpacker #(.WORD_W(WW), .ADDR_W(AW), .WC_W(CW)) i_chan_out_unpacker (
    .clk(clk), .rst(rst), .conn_valid(conn_valid), .conn_width(conn_width),
    .conn_cpw(conn_cpw), .conn_func(conn_func), .conn_zwc_en(conn_zwc_en),
    .conn_eor_en(conn_eor_en), .ion(ion), .ilc_valid(ilc_valid),
    .ilc_addr(ilc_addr), .ilc_count(ilc_count), .pword_valid(pword_valid),
    .pword_data(pword_data), .pword_refused(pword_refused), .top_cmd(top_cmd),
    .dev_xfr(dev_xfr), .dev_ordy(dev_ordy), .dev_eor(dev_eor),
    .char_valid(char_valid), .char_data(char_data), .char_ack(char_ack),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .wreor(wreor), .disc(disc), .irq_zwc(irq_zwc), .irq_eor(irq_eor),
    .irq_eow(irq_eow), .rate_err(rate_err), .connected(connected), .rec_gap(rec_gap));

  logic [WW-1:0] mem [0:255];
  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[7:0]];

  int checks = 0, errors = 0;
  int n_wreor, n_disc, n_zwc, n_eor, n_eow, n_ref, n_req, nrec, want;
  logic [AW-1:0] last_addr;
  bit kick, auto_eor;
  logic [WW-1:0] rec [0:63];

  // device model and event counters
  always @(negedge clk) begin
    dev_xfr_m = 1'b0;
    char_ack  = 1'b0;
    dev_eor   = auto_eor && wreor;
    if (kick) begin dev_xfr_m = 1'b1; kick = 1'b0; end
    if (char_valid && ($urandom_range(0, 2) != 0)) begin
      char_ack = 1'b1;
      rec[nrec[5:0]] = char_data;
      nrec++;
      if (nrec < want) kick = 1'b1;
    end
    if (wreor)         n_wreor++;
    if (disc)          n_disc++;
    if (irq_zwc)       n_zwc++;
    if (irq_eor)       n_eor++;
    if (irq_eow)       n_eow++;
    if (pword_refused) n_ref++;
    if (mem_req) begin n_req++; last_addr = mem_addr; end
  end

  task automatic check_eq(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int chars_per(input int w, input int c);
    if (w == 0) return c + 1;
    if (w == 1) return (c & 1) + 1;
    return 1;
  endfunction

  function automatic logic [WW-1:0] ref_char(input logic [WW-1:0] wd, input int w, input int i);
    if (w == 0) return (wd >> (18 - 6 * i)) & 24'h3f;
    if (w == 1) return (wd >> (12 - 12 * i)) & 24'hfff;
    return wd;
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; conn_valid = 0; conn_width = 0; conn_cpw = 0; conn_func = 0;
    conn_zwc_en = 0; conn_eor_en = 0; ilc_valid = 0; ilc_addr = 0; ilc_count = 0;
    pword_valid = 0; pword_data = 0; top_cmd = 0; dev_xfr_t = 0; dev_ordy = 0;
    wait_cyc(3);
    rst = 1'b0;
    n_wreor = 0; n_disc = 0; n_zwc = 0; n_eor = 0; n_eow = 0; n_ref = 0;
    n_req = 0; nrec = 0; want = 0; kick = 0; auto_eor = 0;
    wait_cyc(1);
  endtask

  task automatic connect(input logic [2:0] f, input int w, input int c, input bit z, input bit e);
    @(negedge clk);
    conn_valid = 1; conn_func = f; conn_width = 2'(w); conn_cpw = 2'(c);
    conn_zwc_en = z; conn_eor_en = e;
    @(negedge clk); conn_valid = 0;
  endtask

  task automatic ilc(input int a, input int n);
    @(negedge clk); ilc_valid = 1; ilc_addr = AW'(a); ilc_count = CW'(n);
    @(negedge clk); ilc_valid = 0;
  endtask

  task automatic load(input logic [WW-1:0] wd);
    @(negedge clk); pword_valid = 1; pword_data = wd;
    @(negedge clk); pword_valid = 0;
  endtask

  task automatic pulse_top();
    @(negedge clk); top_cmd = 1; @(negedge clk); top_cmd = 0;
  endtask

  task automatic pump(input int n);
    @(negedge clk); #1;
    want = nrec + n; kick = 1;
    for (int k = 0; k < 3000 && nrec < want; k++) @(negedge clk);
    wait_cyc(10);
  endtask

  task automatic run_ilc(input logic [2:0] f, input int w, input int c, input bit z,
                         input bit e, input int a, input int nw, input string req);
    int per = chars_per(w, c);
    for (int i = 0; i < nw; i++) mem[a + i] = WW'($urandom);
    connect(f, w, c, z, e);
    ilc(a, nw);
    pump(nw * per);
    check_eq({req, " char count"}, nrec, nw * per);
    for (int i = 0; i < nw * per; i++)
      check_eq({req, " char value"}, rec[i], ref_char(mem[a + i / per], w, i % per));
  endtask

  initial begin
    #600000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [WW-1:0] wd;
    void'($urandom(32'h1f2e3d));
    ion = 1'b1;
    do_reset();
    // R1 reset state
    check_eq("R1 connected after reset", connected, 0);
    check_eq("R1 outputs idle", {char_valid, wreor, disc, rate_err, rec_gap, mem_req}, 0);

    // R2 R4 R7 compatible 6-bit, four chars per word
    run_ilc(3'b000, 0, 3, 0, 0, 5, 3, "R2");
    check_eq("R4 memory requests", n_req, 3);
    check_eq("R4 last address", last_addr, 7);
    check_eq("R7 zwc irq with ion", n_zwc, 1);
    check_eq("R7 disconnect", n_disc, 1);
    check_eq("R7 connected low", connected, 0);

    // R7 without ion
    do_reset(); ion = 0;
    run_ilc(3'b000, 1, 1, 0, 0, 20, 2, "R3 12-bit");
    check_eq("R7 no zwc with ion off", n_zwc, 0);
    check_eq("R7 disconnect ion off", n_disc, 1);
    ion = 1;

    // R8 R13 record-disconnect, 12-bit, device answers end of record
    do_reset(); auto_eor = 1;
    run_ilc(3'b100, 1, 1, 1, 1, 30, 2, "R3 12-bit record");
    check_eq("R8 zwc enabled", n_zwc, 1);
    check_eq("R8 record wreor", n_wreor, 1);
    check_eq("R13 eor irq", n_eor, 1);
    check_eq("R13 non-proceed disconnect", n_disc, 1);

    // R8 signal-disconnect, 24-bit
    do_reset();
    run_ilc(3'b110, 2, 0, 0, 1, 40, 3, "R3 24-bit");
    check_eq("R8 zwc disabled", n_zwc, 0);
    check_eq("R8 sigdisc eor", n_eor, 1);
    check_eq("R8 sigdisc no wreor", n_wreor, 0);
    check_eq("R8 sigdisc disconnect", n_disc, 1);

    // R8 signal-proceed without terminate-output
    do_reset();
    run_ilc(3'b111, 2, 0, 1, 1, 50, 2, "R8 sigproc");
    check_eq("R8 sigproc no wreor", n_wreor, 0);
    check_eq("R8 sigproc stays connected", connected, 1);

    // R8 R10 R13 signal-proceed with deferred terminate-output
    do_reset(); auto_eor = 1;
    for (int i = 0; i < 2; i++) mem[60 + i] = WW'($urandom);
    connect(3'b111, 2, 0, 1, 1);
    ilc(60, 2);
    pulse_top();
    wait_cyc(2);
    check_eq("R10 deferred while interlace on", n_wreor, 0);
    pump(2);
    check_eq("R8 sigproc wreor with pending", n_wreor, 1);
    check_eq("R13 proceed eor irq", n_eor, 1);
    check_eq("R13 proceed stays connected", connected, 1);
    check_eq("R13 record gap", rec_gap, 1);

    // R6 rate error
    do_reset();
    connect(3'b000, 2, 0, 0, 0);
    @(negedge clk); dev_xfr_t = 1; @(negedge clk); dev_xfr_t = 0;
    wait_cyc(3);
    check_eq("R6 rate error", rate_err, 1);
    check_eq("R6 no char", nrec, 0);

    // R11 R9 R10 program loads, 6-bit two chars
    do_reset();
    connect(3'b000, 0, 1, 0, 0);
    check_eq("R1 connected after connect", connected, 1);
    wd = 24'h9a5c3f;
    load(wd);
    load(24'h123456);
    wait_cyc(2);
    check_eq("R11 refused while full", n_ref, 1);
    pump(2);
    check_eq("R11 first char unchanged", rec[0], ref_char(wd, 0, 0));
    check_eq("R11 second char unchanged", rec[1], ref_char(wd, 0, 1));
    check_eq("R9 eow on empty", n_eow, 1);
    check_eq("R9 no wreor without pending", n_wreor, 0);
    load(24'h0f0f0f);
    pulse_top();
    wait_cyc(3);
    check_eq("R10 deferred while data", n_wreor, 0);
    pump(2);
    check_eq("R9 pending wreor on empty", n_wreor, 1);
    check_eq("R9 no eow with pending", n_eow, 1);
    pulse_top();
    wait_cyc(3);
    check_eq("R10 idle immediate wreor", n_wreor, 2);

    // R10 terminate-output in the emptying cycle
    do_reset();
    connect(3'b000, 2, 0, 0, 0);
    load(24'habcdef);
    dev_xfr_t = 1;
    @(negedge clk); dev_xfr_t = 0; top_cmd = 1;
    @(negedge clk); top_cmd = 0;
    wait_cyc(5);
    check_eq("R10 same-cycle char", rec[0], 24'habcdef);
    check_eq("R10 same-cycle wreor", n_wreor, 1);
    check_eq("R10 same-cycle no eow", n_eow, 0);
    load(24'h111111);
    pump(1);
    check_eq("R10 pending consumed, eow next", n_eow, 1);
    check_eq("R10 no extra wreor", n_wreor, 1);

    // R12 wake flag and load+ready overlap
    do_reset();
    connect(3'b000, 2, 0, 0, 0);
    @(negedge clk); dev_ordy = 1; @(negedge clk); dev_ordy = 0;
    wait_cyc(4);
    check_eq("R12 no char from wake", nrec, 0);
    check_eq("R12 no rate error", rate_err, 0);
    load(24'h5a5a5a);
    wait_cyc(5);
    check_eq("R11 wake resumes transfer", nrec, 1);
    @(negedge clk); pword_valid = 1; pword_data = 24'h777000; dev_ordy = 1;
    @(negedge clk); pword_valid = 0; dev_ordy = 0;
    wait_cyc(5);
    check_eq("R12 load with ready", nrec, 2);
    check_eq("R12 load with ready data", rec[1], 24'h777000);

    // random interlace runs, compatible mode
    for (int it = 0; it < 20; it++) begin
      int w = $urandom_range(0, 2);
      int c = $urandom_range(0, 3);
      int nw = $urandom_range(1, 4);
      int a = $urandom_range(0, 200);
      do_reset();
      run_ilc(3'b000, w, c, 0, 0, a, nw, "R2 random");
      check_eq("R4 random fetch count", n_req, nw);
      check_eq("R7 random disconnect", n_disc, 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule